// File: doc/BRIEF.md
# Serial Peripheral DMA Gate and Interrupt Combiner

This block sits beside a serial bus engine and decides two things for it: whether the engine's receive and transmit DMA requests reach the DMA controller, and whether any of its events should raise the one interrupt line. One 8-bit control word holds two DMA enables, two end-of-block flags and three interrupt masks. Two transfer counters, one per direction, count down the remaining DMA transfers. A counter's arrival at zero ends its block: the matching DMA enable drops and the matching end-of-block flag latches, both on the same clock edge.

Software programs the block through a synchronous write strobe for the control word and a separate load strobe for each counter. It reads the control word and both counts back combinationally. An end-of-block flag can only be cleared by software. Clearing it also removes the interrupt it was raising. The masks select which events reach the interrupt line and never touch DMA request gating.

Top module: `sbus_dma_irq_ctl`

## Requirements
- R1: After reset the control word reads 0x00, both counts read 0, `irq` is 0 and both gated DMA requests are 0.
- R2: A control write sets bit 7 (receive DMA enable), bit 6 (transmit DMA enable) and bits 2..0 (masks: error, receive, transmit) to the written values on the next edge. Bit 3 always reads 0, even after a 1 is written to it.
- R3: Each gated request output is 1 exactly when its raw request is 1, its DMA enable is 1 and its count is nonzero. Mask bits 2..0 have no effect on the gated requests.
- R4: A counter loads the `cnt_wdata` value when its load strobe is high. Without a load, it decrements by one on each edge where its acknowledge is high, its DMA enable is 1 and its count is nonzero. Otherwise it holds its value.
- R5: On the edge where a count decrements from 1 to 0, the matching DMA enable clears and the matching end-of-block flag sets. Bit 5 is the receive flag and bit 4 is the transmit flag.
- R6: Writing 1 to bit 5 or bit 4 leaves that flag unchanged. Writing 0 clears it. A cleared flag stops driving `irq`.
- R7: `irq` is registered. It is high one edge after any of these conditions holds: error event with bit 2 set; data-received event or receive flag with bit 1 set; ready-to-transmit event or transmit flag with bit 0 set.
- R8: If a control write that sets a DMA enable lands on the terminal-count edge, the enable ends at 0.
- R9: A counter load on the same edge as an acknowledge takes priority: the count becomes the loaded value and no end-of-block occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| rx_cnt_ld | input | 1 | Receive counter load strobe |
| tx_cnt_ld | input | 1 | Transmit counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| rx_cnt_q | output | CNT_W | Receive remaining count |
| tx_cnt_q | output | CNT_W | Transmit remaining count |
| rx_dma_req_in | input | 1 | Raw receive DMA request from the engine |
| tx_dma_req_in | input | 1 | Raw transmit DMA request from the engine |
| rx_dma_req_out | output | 1 | Gated receive DMA request |
| tx_dma_req_out | output | 1 | Gated transmit DMA request |
| rx_dma_ack | input | 1 | Receive transfer acknowledge |
| tx_dma_ack | input | 1 | Transmit transfer acknowledge |
| err_evt | input | 1 | Error event level |
| rxd_evt | input | 1 | Data-received event level |
| txr_evt | input | 1 | Ready-to-transmit event level |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that an acknowledge arrives only as a single-cycle pulse per transfer. They also assume that every input is stable around the sampling edge, and that the event inputs are levels held for at least one edge. The bench changes every input one time unit after a rising edge and holds it for whole cycles. It raises acknowledges only on the edges it counts, and it preserves the end-of-block bits with 1s whenever a write means to change only the enables or masks. The loaded counts stay small, so every terminal count can be predicted edge by edge.

// File: rtl/sbdi_pkg.sv
package sbdi_pkg;
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned B_RX_EN  = 7;
   localparam int unsigned B_TX_EN  = 6;
   localparam int unsigned B_RX_EOB = 5;
   localparam int unsigned B_TX_EOB = 4;
   localparam int unsigned B_RSVD   = 3;
   localparam int unsigned B_M_ERR  = 2;
   localparam int unsigned B_M_RX   = 1;
   localparam int unsigned B_M_TX   = 0;
   localparam int unsigned N_CH     = 2;
   localparam int unsigned CH_RX    = 0;
   localparam int unsigned CH_TX    = 1;

   typedef struct packed {
      logic err;
      logic rx;
      logic tx;
   } irq_mask_t;
endpackage

// File: rtl/sbdi_xfer_count.sv
module sbdi_xfer_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ack,
   input  logic             en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             nz,
   output logic             tc
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;

   assign nz   = (cnt_q != '0);
   assign step = ack & en & nz & ~ld;
   assign tc   = step & (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ld)
         cnt_q <= ld_val;
      else if (step)
         cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/sbdi_ctl_reg.sv
module sbdi_ctl_reg
   import sbdi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             tc_rx,
   input  logic             tc_tx,
   output logic             en_rx,
   output logic             en_tx,
   output logic             eob_rx,
   output logic             eob_tx,
   output irq_mask_t        mask,
   output logic [CTL_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_rx  <= 1'b0;
         en_tx  <= 1'b0;
         eob_rx <= 1'b0;
         eob_tx <= 1'b0;
         mask   <= '0;
      end else begin
         // terminal count outranks any software write
         if (tc_rx)   en_rx <= 1'b0;
         else if (wr) en_rx <= wdata[B_RX_EN];
         if (tc_tx)   en_tx <= 1'b0;
         else if (wr) en_tx <= wdata[B_TX_EN];
         // flags: hardware sets, software may only clear
         if (tc_rx)                          eob_rx <= 1'b1;
         else if (wr && !wdata[B_RX_EOB])    eob_rx <= 1'b0;
         if (tc_tx)                          eob_tx <= 1'b1;
         else if (wr && !wdata[B_TX_EOB])    eob_tx <= 1'b0;
         if (wr) begin
            mask.err <= wdata[B_M_ERR];
            mask.rx  <= wdata[B_M_RX];
            mask.tx  <= wdata[B_M_TX];
         end
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[B_RX_EN]  = en_rx;
      rdata[B_TX_EN]  = en_tx;
      rdata[B_RX_EOB] = eob_rx;
      rdata[B_TX_EOB] = eob_tx;
      rdata[B_RSVD]   = 1'b0;
      rdata[B_M_ERR]  = mask.err;
      rdata[B_M_RX]   = mask.rx;
      rdata[B_M_TX]   = mask.tx;
   end
endmodule

// File: rtl/sbdi_irq_merge.sv
module sbdi_irq_merge
   import sbdi_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  irq_mask_t mask,
   input  logic      err_evt,
   input  logic      rxd_evt,
   input  logic      txr_evt,
   input  logic      eob_rx,
   input  logic      eob_tx,
   output logic      irq
);
   logic irq_d;

   always_comb begin
      irq_d = (mask.err & err_evt)
            | (mask.rx  & (rxd_evt | eob_rx))
            | (mask.tx  & (txr_evt | eob_tx));
   end

   generate
      if (IRQ_REG) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = irq_d;
      end
   endgenerate
endmodule

// File: rtl/sbus_dma_irq_ctl.sv
module sbus_dma_irq_ctl
   import sbdi_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             rx_cnt_ld,
   input  logic             tx_cnt_ld,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] rx_cnt_q,
   output logic [CNT_W-1:0] tx_cnt_q,
   input  logic             rx_dma_req_in,
   input  logic             tx_dma_req_in,
   output logic             rx_dma_req_out,
   output logic             tx_dma_req_out,
   input  logic             rx_dma_ack,
   input  logic             tx_dma_ack,
   input  logic             err_evt,
   input  logic             rxd_evt,
   input  logic             txr_evt,
   output logic             irq
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("sbus_dma_irq_ctl: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [N_CH-1:0]             ch_ld, ch_ack, ch_en, ch_nz, ch_tc, ch_req_in;
   logic [N_CH-1:0][CNT_W-1:0]  ch_cnt;
   logic                        en_rx, en_tx, eob_rx, eob_tx;
   irq_mask_t                   mask;

   assign ch_ld[CH_RX]     = rx_cnt_ld;
   assign ch_ld[CH_TX]     = tx_cnt_ld;
   assign ch_ack[CH_RX]    = rx_dma_ack;
   assign ch_ack[CH_TX]    = tx_dma_ack;
   assign ch_en[CH_RX]     = en_rx;
   assign ch_en[CH_TX]     = en_tx;
   assign ch_req_in[CH_RX] = rx_dma_req_in;
   assign ch_req_in[CH_TX] = tx_dma_req_in;

   logic [N_CH-1:0] ch_req_out;

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         sbdi_xfer_count #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ch_ld[c]),
            .ld_val (cnt_wdata),
            .ack    (ch_ack[c]),
            .en     (ch_en[c]),
            .cnt_q  (ch_cnt[c]),
            .nz     (ch_nz[c]),
            .tc     (ch_tc[c])
         );
         assign ch_req_out[c] = ch_req_in[c] & ch_en[c] & ch_nz[c];
      end
   endgenerate

   sbdi_ctl_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .wdata  (reg_wdata),
      .tc_rx  (ch_tc[CH_RX]),
      .tc_tx  (ch_tc[CH_TX]),
      .en_rx  (en_rx),
      .en_tx  (en_tx),
      .eob_rx (eob_rx),
      .eob_tx (eob_tx),
      .mask   (mask),
      .rdata  (reg_rdata)
   );

   sbdi_irq_merge #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask    (mask),
      .err_evt (err_evt),
      .rxd_evt (rxd_evt),
      .txr_evt (txr_evt),
      .eob_rx  (eob_rx),
      .eob_tx  (eob_tx),
      .irq     (irq)
   );

   assign rx_cnt_q       = ch_cnt[CH_RX];
   assign tx_cnt_q       = ch_cnt[CH_TX];
   assign rx_dma_req_out = ch_req_out[CH_RX];
   assign tx_dma_req_out = ch_req_out[CH_TX];
endmodule

// File: rtl/sbus_dma_irq_ctl_chk.sv
module sbus_dma_irq_ctl_chk #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [7:0]       reg_wdata,
   input logic [7:0]       reg_rdata,
   input logic             rx_cnt_ld,
   input logic             tx_cnt_ld,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [CNT_W-1:0] rx_cnt_q,
   input logic [CNT_W-1:0] tx_cnt_q,
   input logic             rx_dma_req_in,
   input logic             tx_dma_req_in,
   input logic             rx_dma_req_out,
   input logic             tx_dma_req_out,
   input logic             rx_dma_ack,
   input logic             tx_dma_ack,
   input logic             err_evt,
   input logic             rxd_evt,
   input logic             txr_evt,
   input logic             irq
);
   logic rx_end, tx_end, irq_src;
   assign rx_end  = !rx_cnt_ld && rx_dma_ack && reg_rdata[7] && (rx_cnt_q == CNT_W'(1));
   assign tx_end  = !tx_cnt_ld && tx_dma_ack && reg_rdata[6] && (tx_cnt_q == CNT_W'(1));
   assign irq_src = (reg_rdata[2] & err_evt)
                  | (reg_rdata[1] & (rxd_evt | reg_rdata[5]))
                  | (reg_rdata[0] & (txr_evt | reg_rdata[4]));

   // R2
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[3] == 1'b0);
   a_r2_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata[2:0] == $past(reg_wdata[2:0]));
   // R3
   a_r3_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req_out |-> (rx_dma_req_in && reg_rdata[7] && rx_cnt_q != '0));
   a_r3_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req_out |-> (tx_dma_req_in && reg_rdata[6] && tx_cnt_q != '0));
   // R4
   a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_cnt_ld && !(rx_dma_ack && reg_rdata[7])) |=> $stable(rx_cnt_q));
   a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_cnt_ld && !(tx_dma_ack && reg_rdata[6])) |=> $stable(tx_cnt_q));
   // R5 and R8: terminal count clears enable and sets flag, whatever is written
   a_r5_rx_end: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end |=> (!reg_rdata[7] && reg_rdata[5] && rx_cnt_q == '0));
   a_r8_tx_end: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end |=> (!reg_rdata[6] && reg_rdata[4] && tx_cnt_q == '0));
   // R6: flags never set without a terminal count
   a_r6_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[5] && !rx_end) |=> !reg_rdata[5]);
   a_r6_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[4] && !tx_end) |=> !reg_rdata[4]);
   // R9
   a_r9_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt_ld |=> rx_cnt_q == $past(cnt_wdata));
   a_r9_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt_ld |=> tx_cnt_q == $past(cnt_wdata));
   // R7
   generate
      if (IRQ_REG) begin : g_irq_seq
         a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq == $past(irq_src));
      end else begin : g_irq_comb
         a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
            irq == irq_src);
      end
   endgenerate
endmodule

bind sbus_dma_irq_ctl sbus_dma_irq_ctl_chk #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .rx_cnt_ld(rx_cnt_ld), .tx_cnt_ld(tx_cnt_ld),
   .cnt_wdata(cnt_wdata), .rx_cnt_q(rx_cnt_q), .tx_cnt_q(tx_cnt_q),
   .rx_dma_req_in(rx_dma_req_in), .tx_dma_req_in(tx_dma_req_in),
   .rx_dma_req_out(rx_dma_req_out), .tx_dma_req_out(tx_dma_req_out),
   .rx_dma_ack(rx_dma_ack), .tx_dma_ack(tx_dma_ack), .err_evt(err_evt),
   .rxd_evt(rxd_evt), .txr_evt(txr_evt), .irq(irq)
);

// File: tb/sbus_dma_irq_ctl_bench.sv
module sbus_dma_irq_ctl_bench;
   localparam int CLK_P = 10;
   localparam int CNT_W = 16;
   localparam int NVEC  = 10;
   // {mask err,rx,tx, evt err,rxd,txr, expected irq}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b000_111_0, 7'b100_100_1, 7'b100_011_0, 7'b010_010_1, 7'b010_101_0,
      7'b001_001_1, 7'b001_110_0, 7'b111_000_0, 7'b111_101_1, 7'b011_100_0
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 0, rx_cnt_ld = 0, tx_cnt_ld = 0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic [CNT_W-1:0] cnt_wdata = '0, rx_cnt_q, tx_cnt_q;
   logic rx_dma_req_in = 0, tx_dma_req_in = 0, rx_dma_req_out, tx_dma_req_out;
   logic rx_dma_ack = 0, tx_dma_ack = 0, err_evt = 0, rxd_evt = 0, txr_evt = 0, irq;
   int n_chk = 0, n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   sbus_dma_irq_ctl #(.CNT_W(CNT_W)) u_sbus_dma_irq_ctl (.*);

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      reg_wr = 1; reg_wdata = v; tick(); reg_wr = 0;
   endtask

   task automatic ld_cnt(input bit tx, input logic [CNT_W-1:0] v);
      cnt_wdata = v;
      if (tx) tx_cnt_ld = 1; else rx_cnt_ld = 1;
      tick(); rx_cnt_ld = 0; tx_cnt_ld = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P*200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rx_dma_req_in = 1; tx_dma_req_in = 1;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 rdata", reg_rdata, 8'h00);
      chk("R1 rx cnt", rx_cnt_q, 0);
      chk("R1 tx cnt", tx_cnt_q, 0);
      chk("R1 irq", irq, 0);
      chk("R1 reqs", {rx_dma_req_out, tx_dma_req_out}, 0);
      rst_n = 1;
      tick();

      // R7: mask / event table
      for (int i = 0; i < NVEC; i++) begin
         {err_evt, rxd_evt, txr_evt} = VEC[i][3:1];
         wr_reg({5'b00000, VEC[i][6:4]});
         tick();
         chk($sformatf("R7 vec%0d irq", i), irq, VEC[i][0]);
      end
      {err_evt, rxd_evt, txr_evt} = 3'b000;
      wr_reg(8'h00);

      // R2 / R6: write all ones; flags stay 0, bit 3 reads 0
      wr_reg(8'hFF);
      chk("R2 write ones", reg_rdata, 8'hC7);
      wr_reg(8'h00);
      chk("R2 write zeros", reg_rdata, 8'h00);

      // R3: gating
      wr_reg(8'h80);
      chk("R3 zero count blocks", rx_dma_req_out, 0);
      ld_cnt(0, 3);
      chk("R3 rx passes", rx_dma_req_out, 1);
      chk("R3 tx disabled", tx_dma_req_out, 0);
      wr_reg(8'h87);
      chk("R3 masks no effect", rx_dma_req_out, 1);
      wr_reg(8'h80);

      // R4: decrement rules
      wr_reg(8'h00);
      rx_dma_ack = 1; tick(); rx_dma_ack = 0;
      chk("R4 ack while disabled", rx_cnt_q, 3);
      wr_reg(8'h80);
      rx_dma_ack = 1; tick(); tick(); rx_dma_ack = 0;
      chk("R4 two decrements", rx_cnt_q, 1);

      // R5: terminal count
      rx_dma_ack = 1; tick(); rx_dma_ack = 0;
      chk("R5 rx cnt zero", rx_cnt_q, 0);
      chk("R5 en cleared flag set", reg_rdata, 8'h20);
      chk("R5 req dropped", rx_dma_req_out, 0);

      // R7 / R6: receive flag interrupt then clear
      wr_reg(8'h22); tick();
      chk("R7 rx flag irq", irq, 1);
      wr_reg(8'h02);
      chk("R6 rx flag cleared", reg_rdata, 8'h02);
      tick();
      chk("R6 irq withdrawn", irq, 0);

      // R8: enable write on terminal edge loses
      ld_cnt(1, 1);
      wr_reg(8'h40);
      chk("R8 tx enabled", reg_rdata, 8'h40);
      tx_dma_ack = 1; reg_wr = 1; reg_wdata = 8'h40;
      tick(); tx_dma_ack = 0; reg_wr = 0;
      chk("R8 hw clear wins", reg_rdata, 8'h10);
      chk("R8 tx cnt zero", tx_cnt_q, 0);

      // R7 / R6: transmit flag
      wr_reg(8'h11); tick();
      chk("R7 tx flag irq", irq, 1);
      wr_reg(8'h31);
      chk("R6 write one keeps flag", reg_rdata, 8'h11);
      wr_reg(8'h01); tick();
      chk("R6 tx irq withdrawn", irq, 0);

      // R9: load beats acknowledge
      wr_reg(8'h80);
      ld_cnt(0, 2);
      rx_dma_ack = 1; ld_cnt(0, 9); rx_dma_ack = 0;
      chk("R9 load wins", rx_cnt_q, 9);
      ld_cnt(0, 1);
      rx_dma_ack = 1; ld_cnt(0, 4); rx_dma_ack = 0;
      chk("R9 load at count 1", rx_cnt_q, 4);
      chk("R9 no end of block", reg_rdata, 8'h80);

      finish_run();
   end
endmodule